// File: doc/BRIEF.md
# Atomic Wide Register Shadow Buffer

This block holds one hardware-side register that is wider than the software register bus. Software never touches that live register directly. It goes through a bank of bus-width staging words that are mapped at consecutive bus addresses. Word `i` covers bits `[i*BUS_W +: BUS_W]` of the wide value.

One of the staging words is the trigger word. A parameter selects it as either the least or the most significant word.

- **Writes.** Software fills the other words first, then writes the trigger word. That write copies the whole staging bank, with the trigger word taking the new bus data, into the live register in a single cycle. Hardware therefore never sees a half-updated value.
- **Reads.** Software reads the trigger word first. That read returns the live word and, in the same cycle, captures the entire live value into the staging bank. Reads of the remaining words then return that coherent snapshot, even if hardware changes the live register in the meantime.

A typical use is a wide up/down counter. Its carry or borrow at a threshold must be seen together with every other bit.

Hardware can also load the live register through its own strobe. A software commit in the same cycle wins over it. Each software commit produces a one-cycle update strobe towards the hardware side.

Top module: `wide_shadow_reg`

## Requirements
- R1: After synchronous reset, the live value, the update strobe and the read data are all zero, and every staging word reads back zero.
- R2: A write to a word other than the trigger word stores the bus data in that staging word and leaves the live value unchanged.
- R3: A write to the trigger word loads the live value on the next clock edge. The loaded value is the staging words, with the trigger word replaced by the written data. The update strobe is high for exactly the cycle after that write and low after every other cycle.
- R4: A read of the trigger word returns, one cycle later, the live value's word at that address. The same read copies the entire live value into all staging words.
- R5: A read of a word other than the trigger word returns that staging word one cycle later and changes neither the live value nor the staging bank.
- R6: When the hardware load strobe is high and no trigger write occurs in that cycle, the live value takes the hardware load value on the next edge.
- R7: When a trigger write and the hardware load strobe occur in the same cycle, the software commit is applied and the hardware load value is discarded.
- R8: With `TRIGGER_ON_LSW` = 1 the trigger word is address 0. With `TRIGGER_ON_LSW` = 0 it is address `N_WORDS-1`.
- R9: The read data register changes only on a cycle following a read. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | $clog2(N_WORDS) | Word address within the staging bank |
| bus_wr | input | 1 | Write access this cycle |
| bus_rd | input | 1 | Read access this cycle |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid the cycle after a read |
| hw_load | input | 1 | Hardware load strobe for the live register |
| hw_load_val | input | BUS_W*N_WORDS | Value loaded by the hardware strobe |
| live_q | output | BUS_W*N_WORDS | Live wide register seen by hardware |
| live_upd | output | 1 | One-cycle pulse after a software commit |

## Verification
The checker takes for granted that a read and a write never occur in the same cycle on the register bus, since the block gives such a pair no defined meaning. It checks that rule as an input property. The stimulus keeps to this rule by encoding each operation as exactly one of write, read, hardware load, write with hardware load, or idle. Two instances, one per trigger choice, receive identical traffic, so a single access sequence commits or snapshots on one instance while it only stages on the other.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    // Source that feeds the live register on the next edge
    typedef enum logic [1:0] {
        LIVE_KEEP   = 2'd0,
        LIVE_COMMIT = 2'd1,
        LIVE_HWLOAD = 2'd2
    } live_src_e;

    // Decoded bus access
    typedef struct packed {
        logic commit;     // write to the trigger word
        logic snap;       // read of the trigger word
        logic rd_any;     // any read access
        logic hit;        // address maps to a staging word
    } bus_dec_t;

    function automatic int trig_word(int n_words, bit on_lsw);
        return on_lsw ? 0 : n_words - 1;
    endfunction

    // Software commit outranks the hardware load
    function automatic live_src_e pick_src(logic commit, logic hw_load);
        if (commit)
            return LIVE_COMMIT;
        else if (hw_load)
            return LIVE_HWLOAD;
        return LIVE_KEEP;
    endfunction

endpackage

// File: rtl/wsb_decode.sv
module wsb_decode
    import wsb_pkg::*;
#(
    parameter int N_WORDS = 4,
    parameter int TRIG    = 0,
    localparam int AW     = $clog2(N_WORDS)
) (
    input  logic [AW-1:0]      addr,
    input  logic               wr,
    input  logic               rd,
    output logic [N_WORDS-1:0] stage_we,
    output bus_dec_t           dec
);
    localparam logic [AW:0]   N_EXT  = (AW+1)'(N_WORDS);
    localparam logic [AW-1:0] TRIG_A = AW'(TRIG);

    logic hit;
    assign hit = ({1'b0, addr} < N_EXT);

    always_comb begin
        dec.hit    = hit;
        dec.commit = wr && hit && (addr == TRIG_A);
        dec.snap   = rd && hit && (addr == TRIG_A);
        dec.rd_any = rd;
    end

    for (genvar i = 0; i < N_WORDS; i++) begin : g_we
        assign stage_we[i] = wr && hit && (addr == AW'(i));
    end

endmodule

// File: rtl/wsb_stage.sv
module wsb_stage #(
    parameter int BUS_W   = 8,
    parameter int N_WORDS = 4,
    localparam int W      = BUS_W * N_WORDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_WORDS-1:0] stage_we,
    input  logic               snap,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [W-1:0]       live_q,
    output logic [W-1:0]       stage_q
);
    logic [BUS_W-1:0] words [N_WORDS];

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= '0;
            else if (snap)
                words[i] <= live_q[i*BUS_W +: BUS_W];
            else if (stage_we[i])
                words[i] <= wdata;
        end
        assign stage_q[i*BUS_W +: BUS_W] = words[i];
    end

endmodule

// File: rtl/wsb_live.sv
module wsb_live
    import wsb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  logic [W-1:0] commit_val,
    input  logic         hw_load,
    input  logic [W-1:0] hw_val,
    output logic [W-1:0] live_q,
    output logic         live_upd
);
    live_src_e src;
    assign src = pick_src(commit, hw_load);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= '0;
            live_upd <= 1'b0;
        end else begin
            live_upd <= (src == LIVE_COMMIT);
            case (src)
                LIVE_COMMIT: live_q <= commit_val;
                LIVE_HWLOAD: live_q <= hw_val;
                default:     live_q <= live_q;
            endcase
        end
    end

endmodule

// File: rtl/wsb_rdata.sv
module wsb_rdata #(
    parameter int BUS_W   = 8,
    parameter int N_WORDS = 4,
    parameter int TRIG    = 0,
    localparam int W      = BUS_W * N_WORDS,
    localparam int AW     = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             rd,
    input  logic [W-1:0]     stage_q,
    input  logic [W-1:0]     live_q,
    output logic [BUS_W-1:0] rdata
);
    logic [BUS_W-1:0] word_sel;

    // The trigger word is served from the live value, the others from staging
    always_comb begin
        word_sel = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (addr == AW'(i))
                word_sel = (i == TRIG) ? live_q[i*BUS_W +: BUS_W]
                                       : stage_q[i*BUS_W +: BUS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= word_sel;
    end

endmodule

// File: rtl/wide_shadow_reg.sv
module wide_shadow_reg
    import wsb_pkg::*;
#(
    parameter int BUS_W          = 8,
    parameter int N_WORDS        = 4,
    parameter bit TRIGGER_ON_LSW = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(N_WORDS)-1:0]   bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [BUS_W-1:0]             bus_wdata,
    output logic [BUS_W-1:0]             bus_rdata,
    input  logic                         hw_load,
    input  logic [BUS_W*N_WORDS-1:0]     hw_load_val,
    output logic [BUS_W*N_WORDS-1:0]     live_q,
    output logic                         live_upd
);
    localparam int W    = BUS_W * N_WORDS;
    localparam int TRIG = trig_word(N_WORDS, TRIGGER_ON_LSW);

    logic [N_WORDS-1:0] stage_we;
    bus_dec_t           dec;
    logic [W-1:0]       stage_q;
    logic [W-1:0]       commit_val;

    wsb_decode #(.N_WORDS(N_WORDS), .TRIG(TRIG)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .stage_we (stage_we),
        .dec      (dec)
    );

    wsb_stage #(.BUS_W(BUS_W), .N_WORDS(N_WORDS)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .stage_we (stage_we),
        .snap     (dec.snap),
        .wdata    (bus_wdata),
        .live_q   (live_q),
        .stage_q  (stage_q)
    );

    // Commit image: staged words with the trigger word taken from the bus
    for (genvar i = 0; i < N_WORDS; i++) begin : g_img
        if (i == TRIG) begin : g_trig
            assign commit_val[i*BUS_W +: BUS_W] = bus_wdata;
        end else begin : g_stg
            assign commit_val[i*BUS_W +: BUS_W] = stage_q[i*BUS_W +: BUS_W];
        end
    end

    wsb_live #(.W(W)) u_live (
        .clk        (clk),
        .rst        (rst),
        .commit     (dec.commit),
        .commit_val (commit_val),
        .hw_load    (hw_load),
        .hw_val     (hw_load_val),
        .live_q     (live_q),
        .live_upd   (live_upd)
    );

    wsb_rdata #(.BUS_W(BUS_W), .N_WORDS(N_WORDS), .TRIG(TRIG)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .rd      (dec.rd_any),
        .stage_q (stage_q),
        .live_q  (live_q),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/wide_shadow_reg_chk.sv
module wide_shadow_reg_chk #(
    parameter int BUS_W          = 8,
    parameter int N_WORDS        = 4,
    parameter bit TRIGGER_ON_LSW = 1'b1,
    localparam int W             = BUS_W * N_WORDS,
    localparam int AW            = $clog2(N_WORDS)
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             hw_load,
    input logic [W-1:0]     hw_load_val,
    input logic [W-1:0]     live_q,
    input logic             live_upd
);
    localparam int          TRIG   = TRIGGER_ON_LSW ? 0 : N_WORDS - 1;
    localparam logic [AW-1:0] TRIG_A = AW'(TRIG);

    logic trig_wr;
    assign trig_wr = bus_wr && (bus_addr == TRIG_A);

    // input rule: one access kind per cycle
    single_access_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (live_q == '0 && !live_upd && bus_rdata == '0));

    // R2
    stage_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !trig_wr && !hw_load) |=> $stable(live_q));

    // R3
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig_wr |=> live_upd);

    // R3
    no_stray_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !trig_wr |=> !live_upd);

    // R5
    read_keeps_live_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !hw_load) |=> $stable(live_q));

    // R6
    hw_load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_load && !trig_wr) |=> live_q == $past(hw_load_val));

    // R7
    commit_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_load && trig_wr) |=> live_q[TRIG*BUS_W +: BUS_W] == $past(bus_wdata));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind wide_shadow_reg wide_shadow_reg_chk #(
    .BUS_W(BUS_W), .N_WORDS(N_WORDS), .TRIGGER_ON_LSW(TRIGGER_ON_LSW)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_load(hw_load),
    .hw_load_val(hw_load_val), .live_q(live_q), .live_upd(live_upd)
);

// File: tb/test_wide_shadow_reg.sv
module test_wide_shadow_reg;
    localparam int BW = 8;
    localparam int N  = 4;
    localparam int W  = BW * N;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0, rd = 1'b0, hl = 1'b0;
    logic [BW-1:0] wdata = '0;
    logic [W-1:0]  hval = '0;

    logic [BW-1:0] rdata [2];
    logic [W-1:0]  live  [2];
    logic          upd   [2];

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    wide_shadow_reg #(.BUS_W(BW), .N_WORDS(N), .TRIGGER_ON_LSW(1'b1)) i_wide_shadow_reg (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata[0]), .hw_load(hl), .hw_load_val(hval),
        .live_q(live[0]), .live_upd(upd[0])
    );

    wide_shadow_reg #(.BUS_W(BW), .N_WORDS(N), .TRIGGER_ON_LSW(1'b0)) i_wide_shadow_reg_msw (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata[1]), .hw_load(hl), .hw_load_val(hval),
        .live_q(live[1]), .live_upd(upd[1])
    );

    // Reference model, one per trigger choice
    int            trig [2] = '{0, N-1};
    logic [BW-1:0] m_stage [2][N];
    logic [W-1:0]  m_live [2];
    logic          m_upd [2];
    logic [BW-1:0] m_rdata [2];

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic model_op(logic w, logic r, int a, logic [BW-1:0] d, logic h, logic [W-1:0] hv);
        for (int j = 0; j < 2; j++) begin
            logic [W-1:0] old;
            logic [W-1:0] img;
            old = m_live[j];
            m_upd[j] = 1'b0;
            if (w) m_stage[j][a] = d;
            if (r) begin
                if (a == trig[j]) begin
                    m_rdata[j] = old[a*BW +: BW];
                    for (int k = 0; k < N; k++) m_stage[j][k] = old[k*BW +: BW];
                end else begin
                    m_rdata[j] = m_stage[j][a];
                end
            end
            if (w && a == trig[j]) begin
                for (int k = 0; k < N; k++) img[k*BW +: BW] = m_stage[j][k];
                m_live[j] = img;
                m_upd[j]  = 1'b1;
            end else if (h) begin
                m_live[j] = hv;
            end
        end
    endtask

    task automatic do_op(logic w, logic r, int a, logic [BW-1:0] d, logic h, logic [W-1:0] hv);
        @(negedge clk);
        wr = w; rd = r; addr = AW'(a); wdata = d; hl = h; hval = hv;
        model_op(w, r, a, d, h, hv);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; hl = 1'b0;
        for (int j = 0; j < 2; j++) begin
            string tag;
            if (w)      tag = (a == trig[j]) ? (h ? "R7" : "R3") : "R2";
            else if (r) tag = (a == trig[j]) ? "R4" : "R5";
            else        tag = h ? "R6" : "R9";
            check(tag, j ? "live_msw" : "live_lsw", live[j], m_live[j]);
            check(w ? "R3" : tag, j ? "upd_msw" : "upd_lsw", W'(upd[j]), W'(m_upd[j]));
            check(r ? tag : "R9", j ? "rdata_msw" : "rdata_lsw", W'(rdata[j]), W'(m_rdata[j]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        for (int j = 0; j < 2; j++) begin
            m_live[j] = '0; m_upd[j] = 1'b0; m_rdata[j] = '0;
            for (int k = 0; k < N; k++) m_stage[j][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        for (int j = 0; j < 2; j++) begin
            check("R1", "live", live[j], '0);
            check("R1", "upd", W'(upd[j]), '0);
            check("R1", "rdata", W'(rdata[j]), '0);
        end
        // R1: staging words read back zero (non-trigger on both instances)
        for (int a = 1; a < N - 1; a++) begin
            do_op(1'b0, 1'b1, a, '0, 1'b0, '0);
            check("R1", "stage_word", W'(rdata[0]), '0);
        end

        // R8: word 0 commits only on the LSW-triggered instance
        do_op(1'b1, 1'b0, 0, 8'hA5, 1'b0, '0);
        check("R8", "lsw_commit", live[0], 32'h0000_00A5);
        check("R8", "msw_no_commit", live[1], '0);
        // R8: word N-1 commits only on the MSW-triggered instance
        do_op(1'b1, 1'b0, N-1, 8'h3C, 1'b0, '0);
        check("R8", "msw_commit", live[1], 32'h3C00_00A5);
        check("R8", "lsw_no_commit", live[0], 32'h0000_00A5);

        // R4: counter rollover cannot tear a read on the LSW instance
        do_op(1'b0, 1'b0, 0, '0, 1'b1, 32'h00FF_FFFF);
        do_op(1'b0, 1'b1, 0, '0, 1'b0, '0);
        check("R4", "snap_low", W'(rdata[0]), 32'h0000_00FF);
        do_op(1'b0, 1'b0, 0, '0, 1'b1, 32'h0100_0000);
        for (int a = 1; a < N; a++) begin
            do_op(1'b0, 1'b1, a, '0, 1'b0, '0);
            check("R4", "snap_upper", W'(rdata[0]), W'(a == 3 ? 8'h00 : 8'hFF));
        end

        // Pseudo-random sweep over every operation kind and address
        lf = 32'h1BADC0DE;
        for (int it = 0; it < 600; it++) begin
            int kind;
            int a;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            kind = int'(lf[2:0]);
            a    = int'(lf[4:3]);
            case (kind)
                0, 1, 2: do_op(1'b1, 1'b0, a, lf[15:8], 1'b0, '0);
                3, 4:    do_op(1'b0, 1'b1, a, '0, 1'b0, '0);
                5:       do_op(1'b0, 1'b0, a, '0, 1'b1, {lf[7:0], lf[31:8]});
                6:       do_op(1'b1, 1'b0, a, lf[23:16], 1'b1, {lf[15:0], lf[31:16]});
                default: do_op(1'b0, 1'b0, a, '0, 1'b0, '0);
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule